// File: doc/BRIEF.md
# Systolic FIR Cell

One stage of a weight-stationary systolic convolution array. The cell keeps a filter coefficient in a local register. It takes a sample and a running partial sum from the cell on its left. It passes the sample on unchanged, and it passes the sum on after adding coefficient times sample. Samples and sums both move rightward, but a sample spends two clocks in each cell while a sum spends one. Because of that skew, each sum meets a new sample at every cell without any wire shared by all cells.

An N-tap filter is built by wiring N copies output-to-input. The head of the chain gets a zero sum with its valid flag held high. A valid flag rides beside each sample and each sum, so the end of the chain marks only outputs whose whole tap window held real samples. Arithmetic is unsigned and wraps modulo 2^DATA_W.

Top module: `sfir_pe`

## Requirements
- R1: While rst_ni is low and after it rises, x_o, x_vld_o, y_o and y_vld_o are 0 and the coefficient is 0. A chain streaming samples with no coefficient ever loaded therefore yields valid sums equal to 0.
- R2: x_o and x_vld_o in cycle c+2 equal x_i and x_vld_i in cycle c. The sample value is never altered.
- R3: y_o in cycle c+2 equals y_i in cycle c+1 plus the coefficient times x_i in cycle c.
- R4: The R3 sum is unsigned and truncated to DATA_W bits with wraparound; no saturation. For example, a coefficient of 0xFFFF times a sample of 0xFFFF contributes 1 in 16 bits.
- R5: When coef_ld_i is high at a rising edge, the coefficient takes coef_i and is used for every later sum.
- R6: When coef_ld_i is low, coef_i has no effect on the coefficient or on any output.
- R7: y_vld_o in cycle c+2 is y_vld_i in cycle c+1 AND x_vld_i in cycle c.
- R8: In a chain of four cells whose head sum is 0 with valid 1, let the sample in cycle n be s(n) and the coefficient of cell k be w(k), with cell 0 at the head. The output in cycle n+5 is the sum of w(k)*s(n-k) for k from 0 to 3. A first sample in cycle 0 gives the first valid output in cycle 8. Back-to-back samples then give one valid output every cycle.
- R9: If any of the four samples in a window has x_vld_i low, the chain output for that window has its valid flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_i | input | DATA_W | Coefficient load value |
| coef_ld_i | input | 1 | Coefficient load strobe |
| x_i | input | DATA_W | Sample from left neighbour |
| x_vld_i | input | 1 | Sample valid from left neighbour |
| y_i | input | DATA_W | Partial sum from left neighbour |
| y_vld_i | input | 1 | Partial sum valid from left neighbour |
| x_o | output | DATA_W | Sample to right neighbour |
| x_vld_o | output | 1 | Sample valid to right neighbour |
| y_o | output | DATA_W | Partial sum to right neighbour |
| y_vld_o | output | 1 | Partial sum valid to right neighbour |

## Verification
The sum and delay properties look back at most two edges. A gate counter holds them off until two clock edges have passed since reset, so they depend on no input value from before reset. The sum property assumes nothing about the coefficient loading during a stream, since it uses the coefficient register value at the relevant edge. The bench's end-to-end model, however, assumes coefficients change only while the chain is idle. For that reason every load is issued between phases, after the pipeline has drained with invalid samples. The bench drives only the head of the chain, holds the head sum at 0 with valid high, and gives each cell its own coefficient input.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
  parameter int unsigned SFIR_DW       = 16;
  parameter int unsigned SFIR_X_STAGES = 2;  // sample-path depth; sum path is 1
endpackage

// File: rtl/sfir_dly.sv
module sfir_dly #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_regs
    logic [W-1:0] stg [DEPTH];
    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg[i] <= '0;
          else         stg[i] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg[i] <= '0;
          else         stg[i] <= stg[i-1];
      end
    end
    assign q_o = stg[DEPTH-1];
  end
endmodule

// File: rtl/sfir_coef_reg.sv
module sfir_coef_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
endmodule

// File: rtl/sfir_mac.sv
module sfir_mac #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] coef_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic              x_vld_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              y_vld_i,
  output logic [DATA_W-1:0] y_o,
  output logic              y_vld_o
);
  // Product bits above DATA_W cannot reach a wrapped sum, so evaluate at DATA_W.
  logic [DATA_W-1:0] sum_d;
  assign sum_d = y_i + coef_i * x_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      y_o     <= '0;
      y_vld_o <= 1'b0;
    end else begin
      y_o     <= sum_d;
      y_vld_o <= y_vld_i & x_vld_i;
    end
endmodule

// File: rtl/sfir_pe.sv
module sfir_pe
  import sfir_pkg::*;
#(
  parameter int unsigned DATA_W   = SFIR_DW,
  parameter int unsigned X_STAGES = SFIR_X_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] coef_i,
  input  logic              coef_ld_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic              x_vld_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              y_vld_i,
  output logic [DATA_W-1:0] x_o,
  output logic              x_vld_o,
  output logic [DATA_W-1:0] y_o,
  output logic              y_vld_o
);
  localparam int unsigned XW     = DATA_W + 1;   // sample plus valid
  localparam int unsigned X_TAIL = X_STAGES - 1; // stages after the input register

  logic [DATA_W-1:0] coef_q;
  logic [XW-1:0]     x_head_q;
  logic [XW-1:0]     x_tail_q;

  sfir_coef_reg #(.DATA_W(DATA_W)) u_coef (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (coef_ld_i),
    .d_i   (coef_i),
    .q_o   (coef_q)
  );

  sfir_dly #(.W(XW), .DEPTH(1)) u_x_in (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({x_vld_i, x_i}),
    .q_o   (x_head_q)
  );

  sfir_dly #(.W(XW), .DEPTH(X_TAIL)) u_x_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (x_head_q),
    .q_o   (x_tail_q)
  );

  sfir_mac #(.DATA_W(DATA_W)) u_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .coef_i (coef_q),
    .x_i    (x_head_q[DATA_W-1:0]),
    .x_vld_i(x_head_q[DATA_W]),
    .y_i    (y_i),
    .y_vld_i(y_vld_i),
    .y_o    (y_o),
    .y_vld_o(y_vld_o)
  );

  assign x_o     = x_tail_q[DATA_W-1:0];
  assign x_vld_o = x_tail_q[DATA_W];
endmodule

// File: rtl/sfir_pe_chk.sv
module sfir_pe_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned X_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] coef_i,
  input logic              coef_ld_i,
  input logic [DATA_W-1:0] x_i,
  input logic              x_vld_i,
  input logic [DATA_W-1:0] y_i,
  input logic              y_vld_i,
  input logic [DATA_W-1:0] x_o,
  input logic              x_vld_o,
  input logic [DATA_W-1:0] y_o,
  input logic              y_vld_o,
  input logic [DATA_W-1:0] coef_q
);
  logic [1:0] seen_q;  // edges since reset, saturating
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)             seen_q <= '0;
    else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;

  p_x_delay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q >= 2'd2 && X_STAGES == 2) |->
      (x_o == $past(x_i, 2) && x_vld_o == $past(x_vld_i, 2)));

  p_sum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q >= 2'd2) |-> (y_o == $past(y_i) + $past(coef_q) * $past(x_i, 2)));

  p_coef_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_ld_i |=> (coef_q == $past(coef_i)));

  p_coef_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !coef_ld_i |=> $stable(coef_q));

  p_vld_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q >= 2'd2) |-> (y_vld_o == ($past(y_vld_i) && $past(x_vld_i, 2))));
endmodule

bind sfir_pe sfir_pe_chk #(.DATA_W(DATA_W), .X_STAGES(X_STAGES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .coef_i   (coef_i),
  .coef_ld_i(coef_ld_i),
  .x_i      (x_i),
  .x_vld_i  (x_vld_i),
  .y_i      (y_i),
  .y_vld_i  (y_vld_i),
  .x_o      (x_o),
  .x_vld_o  (x_vld_o),
  .y_o      (y_o),
  .y_vld_o  (y_vld_o),
  .coef_q   (coef_q)
);

// File: tb/sfir_pe_bench.sv
module sfir_pe_bench;
  localparam int DW = 16;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [DW-1:0] x_head = '0;
  logic          xv_head = 1'b0;
  logic [DW-1:0] coef_bus [NT];
  logic [NT-1:0] ld_bus = '0;

  logic [DW-1:0] x_l  [NT+1];
  logic          xv_l [NT+1];
  logic [DW-1:0] y_l  [NT+1];
  logic          yv_l [NT+1];

  assign x_l[0]  = x_head;
  assign xv_l[0] = xv_head;
  assign y_l[0]  = '0;
  assign yv_l[0] = 1'b1;

  for (genvar k = 0; k < NT; k++) begin : g_tap
    sfir_pe #(.DATA_W(DW)) u_sfir_pe (
      .clk_i    (clk),
      .rst_ni   (rst_ni),
      .coef_i   (coef_bus[k]),
      .coef_ld_i(ld_bus[k]),
      .x_i      (x_l[k]),
      .x_vld_i  (xv_l[k]),
      .y_i      (y_l[k]),
      .y_vld_i  (yv_l[k]),
      .x_o      (x_l[k+1]),
      .x_vld_o  (xv_l[k+1]),
      .y_o      (y_l[k+1]),
      .y_vld_o  (yv_l[k+1])
    );
  end

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur_req = "R1";

  logic [DW-1:0] exp_q [$];
  logic [DW-1:0] w_m     [NT];
  logic [DW-1:0] coef_nxt[NT];
  logic [NT-1:0] ld_nxt = '0;
  logic [DW-1:0] win_x   [NT];
  logic          win_v   [NT];
  logic [DW-1:0] xh [1024];
  logic          vh [1024];
  int first_in = -1, first_out = -1;
  int vcnt = 0, vfirst = -1, vlast = -1;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  // one cycle of stimulus at the head of the chain, plus model update
  task automatic step(input logic [DW-1:0] xv, input logic vv);
    logic [DW-1:0] acc;
    bit full;
    @(negedge clk);
    x_head  = xv;
    xv_head = vv;
    for (int k = 0; k < NT; k++) begin
      coef_bus[k] = coef_nxt[k];
      ld_bus[k]   = ld_nxt[k];
      if (ld_nxt[k]) w_m[k] = coef_nxt[k];
    end
    ld_nxt = '0;
    xh[cyc & 1023] = xv;
    vh[cyc & 1023] = vv;
    for (int k = NT-1; k > 0; k--) begin
      win_x[k] = win_x[k-1];
      win_v[k] = win_v[k-1];
    end
    win_x[0] = xv;
    win_v[0] = vv;
    full = 1'b1;
    acc  = '0;
    for (int k = 0; k < NT; k++) begin
      full = full & win_v[k];
      acc  = acc + w_m[k] * win_x[k];
    end
    if (full) exp_q.push_back(acc);
    if (vv && first_in < 0) first_in = cyc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0);
  endtask

  task automatic drain_check(input string req);
    idle(12);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && mon_on) begin
      if (yv_l[NT]) begin
        if (first_out < 0) first_out = cyc;
        if (vfirst < 0) vfirst = cyc;
        vlast = cyc;
        vcnt++;
        if (exp_q.size() == 0) chk(1'b0, {cur_req, " R3 R8 unexpected"}, y_l[NT], 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(y_l[NT] == e, {cur_req, " R3 R8"}, y_l[NT], e);
        end
      end
      if (cyc >= 8) begin
        chk(x_l[NT] == xh[(cyc-8) & 1023], "R2 data", x_l[NT], xh[(cyc-8) & 1023]);
        chk(xv_l[NT] == vh[(cyc-8) & 1023], "R2 valid", xv_l[NT], vh[(cyc-8) & 1023]);
      end
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin xh[i] = '0; vh[i] = 1'b0; end
    for (int k = 0; k < NT; k++) begin
      coef_bus[k] = '0; coef_nxt[k] = '0; w_m[k] = '0; win_x[k] = '0; win_v[k] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(x_l[NT] == '0 && xv_l[NT] == 1'b0, "R1 x reset", {xv_l[NT], x_l[NT]}, 0);
    chk(y_l[NT] == '0 && yv_l[NT] == 1'b0, "R1 y reset", {yv_l[NT], y_l[NT]}, 0);
    rst_ni = 1'b1;
    mon_on = 1'b1;

    // R1: no coefficient loaded -> all sums zero
    cur_req = "R1";
    for (int i = 0; i < 8; i++) step(DW'(i + 7), 1'b1);
    drain_check("R1 drain");

    // R5 load, impulse, R8 latency
    cur_req = "R5";
    for (int k = 0; k < NT; k++) coef_nxt[k] = DW'(k + 1);
    ld_nxt = '1;
    idle(2);
    first_in = -1; first_out = -1;
    step(16'd1, 1'b1);
    for (int i = 0; i < 7; i++) step('0, 1'b1);
    drain_check("R5 drain");
    chk(first_out - first_in == 8, "R8 latency", first_out - first_in, 8);

    // R6: garbage on coef_i with strobe low; R8 throughput on a ramp
    cur_req = "R6";
    for (int k = 0; k < NT; k++) coef_nxt[k] = 16'hDEAD ^ DW'(k);
    idle(2);
    @(posedge clk); #1;
    vcnt = 0; vfirst = -1; vlast = -1;
    for (int i = 0; i < 20; i++) step(DW'(i + 1), 1'b1);
    drain_check("R6 drain");
    chk(vcnt == 17, "R8 output count", vcnt, 17);
    chk(vlast - vfirst + 1 == vcnt, "R8 one per cycle", vlast - vfirst + 1, vcnt);

    // R9: bubble in the sample stream; R7 valid gating
    cur_req = "R9 R7";
    @(posedge clk); #1;
    vcnt = 0; vfirst = -1; vlast = -1;
    for (int i = 0; i < 12; i++) step(DW'(3 * i + 2), (i != 6));
    drain_check("R9 drain");
    chk(vcnt == 5, "R9 R7 valid count", vcnt, 5);

    // R4: wraparound with all-ones operands
    cur_req = "R4";
    for (int k = 0; k < NT; k++) coef_nxt[k] = 16'hFFFF;
    ld_nxt = '1;
    idle(2);
    for (int i = 0; i < 6; i++) step(16'hFFFF, 1'b1);
    step(16'h8001, 1'b1);
    drain_check("R4 drain");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule